// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit sits beside an I2C bit engine. The engine sends it one-cycle event pulses: arbitration lost, NACK received, access ready, receive data ready, transmit ready, stop condition seen, and addressed as a target. The unit latches each pulse into a sticky status flag. A mask register enables or disables each flag, and the unit drives one registered interrupt line whenever any enabled flag is set.

Software reads the vector register to find the most urgent pending source. The read returns a small code for the highest-priority enabled flag and clears that flag. Repeated reads therefore walk through the pending events in priority order until the register returns zero.

Two further bits in the status word show live levels from the engine: the bus is busy, and the receive shift register is full. A core-enable input models the controller's module reset. While it is low, every flag is held clear.

Top module: `i2c_irq_vec`

## Requirements
- R1: An event pulse on `ev_i[k]` while `core_en_i` is high sets status flag k at the next clock edge, and the flag stays set until it is cleared. The bit positions are: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as target 6.
- R2: A read of the status register (select 0) returns the flags in bits 6:0, `rx_shift_full_i` live in bit 11 and `bus_busy_i` live in bit 12. All other bits read 0.
- R3: A write to the status register clears flags 2 (access ready) and 5 (stop detected) wherever the write data holds a 1. Write data has no effect on the other flags.
- R4: The mask register (select 1) takes write data bits 6:0. It reads back in bits 6:0, and its upper bits read 0.
- R5: The vector register (select 2) returns 1 + k for the lowest-numbered flag k that is both set and enabled. It returns 0 when no enabled flag is set. Select 3 reads 0.
- R6: A read strobe on the vector register clears, at the next edge, the one flag that the read reported. All other flags are left unchanged.
- R7: When an event pulse and a clear (from a status write or a vector read) hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is a register. After each edge it equals the OR of (flags AND mask) as they stood before that edge.
- R9: While `core_en_i` is low, all flags are cleared at each edge and event pulses are ignored. The mask keeps its value.
- R10: After reset the flags are 0, the mask is 0x27 (stop detected, access ready, NACK and arbitration lost enabled), `irq_o` is 0 and the vector reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_en_i | input | 1 | Module enable; low holds all flags clear |
| ev_i | input | 7 | One-cycle event pulses, one per flag |
| bus_busy_i | input | 1 | Bus-busy level, shown in status bit 12 |
| rx_shift_full_i | input | 1 | Receive-shift-full level, shown in status bit 11 |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 vector |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; it has an effect only on the vector register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Read data is combinational from the state registers. An event pulse, status write or vector read therefore shows up in `reg_rdata_o` just after the next rising edge, and `irq_o` follows one edge later. The bench drives inputs 1 ns after a rising edge and samples outputs at the falling edge. A behavioural model advances on the same rising edges, so every output is compared in the cycle where it is due. Directed checks read the registers within the same window. One of them confirms that `irq_o` is still low in the first cycle after an enabled flag appears and high in the next cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_EV   = 7;
  localparam int DATA_W   = 16;
  localparam int CODE_W   = $clog2(NUM_EV + 1);
  localparam int RSF_BIT  = 11;
  localparam int BUSY_BIT = 12;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_VEC  = 2'd2;

  // flags cleared by writing 1: access ready, stop detected
  localparam logic [NUM_EV-1:0] W1C_BITS     = 7'b010_0100;
  localparam logic [NUM_EV-1:0] MASK_DEFAULT = 7'b010_0111;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[i] <= 1'b0;
      else if (!en_i)     flags_o[i] <= 1'b0;
      else if (set_i[i])  flags_o[i] <= 1'b1;  // set wins over clear
      else if (clr_i[i])  flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N      = 7,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      req_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      hot_o
);
  always_comb begin
    code_o = '0;
    hot_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o = CODE_W'(i + 1);
        hot_o  = '0;
        hot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_en_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              bus_busy_i,
  input  logic              rx_shift_full_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] flags, mask_q, pend, vec_hot, clr;
  logic [CODE_W-1:0] vec_code;
  logic              wr_stat, wr_mask, rd_vec, irq_q;

  assign wr_stat = reg_wr_i && (reg_sel_i == SEL_STAT);
  assign wr_mask = reg_wr_i && (reg_sel_i == SEL_MASK);
  assign rd_vec  = reg_rd_i && (reg_sel_i == SEL_VEC);
  assign pend    = flags & mask_q;

  always_comb begin
    clr = '0;
    if (wr_stat) clr = clr | (reg_wdata_i[NUM_EV-1:0] & W1C_BITS);
    if (rd_vec)  clr = clr | vec_hot;
  end

  irq_flag_bank #(.N(NUM_EV)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (core_en_i),
    .set_i   (ev_i),
    .clr_i   (clr),
    .flags_o (flags)
  );

  irq_prio_enc #(.N(NUM_EV), .CODE_W(CODE_W)) u_enc (
    .req_i  (pend),
    .code_o (vec_code),
    .hot_o  (vec_hot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_DEFAULT;
      irq_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[NUM_EV-1:0];
      irq_q <= |pend;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_STAT: begin
        reg_rdata_o[NUM_EV-1:0] = flags;
        reg_rdata_o[RSF_BIT]    = rx_shift_full_i;
        reg_rdata_o[BUSY_BIT]   = bus_busy_i;
      end
      SEL_MASK: reg_rdata_o[NUM_EV-1:0] = mask_q;
      SEL_VEC:  reg_rdata_o[CODE_W-1:0] = vec_code;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_vec_chk.sv
module i2c_irq_vec_chk
  import i2c_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_en_i,
  input logic [NUM_EV-1:0] ev_i,
  input logic [NUM_EV-1:0] flags_i,
  input logic [NUM_EV-1:0] mask_i,
  input logic [CODE_W-1:0] code_i,
  input logic              rd_vec_i,
  input logic              irq_i
);
  logic [NUM_EV-1:0] pend, code_hot, below;
  assign pend = flags_i & mask_i;
  always_comb begin
    code_hot = '0;
    below    = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (code_i == CODE_W'(i + 1)) code_hot[i] = 1'b1;
      if (code_i > CODE_W'(i + 1))  below[i] = 1'b1;
    end
  end

  // R1
  ev_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_i |=> ((flags_i & $past(ev_i)) == $past(ev_i)));

  // R9
  hold_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_en_i |=> (flags_i == '0));

  // R5
  vec_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (code_i == '0));

  // R5
  vec_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0) |-> (((pend & code_hot) != '0) && ((pend & below) == '0)));

  // R6
  vec_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && (code_i != '0) && ((ev_i & code_hot) == '0))
      |=> ((flags_i & $past(code_hot)) == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($past(pend) != '0));
endmodule

bind i2c_irq_vec i2c_irq_vec_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .core_en_i (core_en_i),
  .ev_i      (ev_i),
  .flags_i   (flags),
  .mask_i    (mask_q),
  .code_i    (vec_code),
  .rd_vec_i  (rd_vec),
  .irq_i     (irq_o)
);

// File: tb/i2c_irq_vec_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_vec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        core_en_i = 1'b1;
  logic [6:0]  ev_i = '0;
  logic        bus_busy_i = 1'b0;
  logic        rx_shift_full_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  i2c_irq_vec dut_i (.*);

  // behavioural reference
  bit [6:0] m_flag, m_mask;
  bit       m_irq;

  function automatic int m_code(bit [6:0] f, bit [6:0] m);
    for (int i = 0; i < 7; i++) if (f[i] && m[i]) return i + 1;
    return 0;
  endfunction

  function automatic bit [15:0] m_rdata();
    case (reg_sel_i)
      2'd0: return {3'b0, bus_busy_i, rx_shift_full_i, 4'b0, m_flag};
      2'd1: return {9'b0, m_mask};
      2'd2: return 16'(m_code(m_flag, m_mask));
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag = '0; m_mask = 7'h27; m_irq = 1'b0;
    end else begin
      bit [6:0] clr;
      int c;
      c = m_code(m_flag, m_mask);
      m_irq = (m_flag & m_mask) != 0;
      clr = '0;
      if (reg_wr_i && reg_sel_i == 2'd0) clr = reg_wdata_i[6:0] & 7'h24;
      if (reg_rd_i && reg_sel_i == 2'd2 && c != 0) clr[c-1] = 1'b1;
      if (reg_wr_i && reg_sel_i == 2'd1) m_mask = reg_wdata_i[6:0];
      m_flag = core_en_i ? ((m_flag & ~clr) | ev_i) : 7'h0;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk("R2/R5 model rdata", reg_rdata_o, m_rdata());
    chk("R8 model irq", {15'b0, irq_o}, {15'b0, m_irq});
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic look(logic [1:0] sel, logic [15:0] exp, string tag);
    reg_sel_i = sel; #0.5;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic pulse(logic [6:0] e);
    ev_i = e; tick(); ev_i = '0;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1; tick(); reg_wr_i = 1'b0;
  endtask

  task automatic pop();
    reg_sel_i = 2'd2; reg_rd_i = 1'b1; tick(); reg_rd_i = 1'b0;
  endtask

  bit done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    look(2'd0, 16'h0000, "R10 status");
    look(2'd1, 16'h0027, "R10 mask");
    look(2'd2, 16'h0000, "R10 vector");
    chk("R10 irq", {15'b0, irq_o}, 16'h0);

    pulse(7'h08);
    look(2'd0, 16'h0008, "R1 rx flag");
    look(2'd2, 16'h0000, "R5 masked off");
    tick();
    chk("R8 masked irq", {15'b0, irq_o}, 16'h0);

    bus_busy_i = 1'b1; rx_shift_full_i = 1'b1;
    look(2'd0, 16'h1808, "R2 levels");
    bus_busy_i = 1'b0; rx_shift_full_i = 1'b0;

    wr(2'd1, 16'hFFFF);
    look(2'd1, 16'h007F, "R4 mask");
    look(2'd2, 16'h0004, "R5 code 4");
    chk("R8 lag", {15'b0, irq_o}, 16'h0);
    tick();
    chk("R8 raised", {15'b0, irq_o}, 16'h1);

    pulse(7'h42);
    look(2'd2, 16'h0002, "R5 priority");
    pop();
    look(2'd2, 16'h0004, "R6 next");
    look(2'd0, 16'h0048, "R6 others kept");
    pop();
    look(2'd2, 16'h0007, "R6 next 7");
    pop();
    look(2'd2, 16'h0000, "R6 empty");

    pulse(7'h25);
    wr(2'd0, 16'h007F);
    look(2'd0, 16'h0001, "R3 w1c");
    look(2'd2, 16'h0001, "R5 code 1");

    ev_i = 7'h04; wr(2'd0, 16'h0004); ev_i = '0;
    look(2'd0, 16'h0005, "R7 set vs write");
    ev_i = 7'h01; pop(); ev_i = '0;
    look(2'd0, 16'h0005, "R7 set vs vector read");

    core_en_i = 1'b0; tick();
    look(2'd0, 16'h0000, "R9 held clear");
    pulse(7'h7F);
    look(2'd0, 16'h0000, "R9 event ignored");
    look(2'd1, 16'h007F, "R9 mask kept");
    tick();
    chk("R9 irq low", {15'b0, irq_o}, 16'h0);
    core_en_i = 1'b1;

    pulse(7'h7F);
    look(2'd0, 16'h007F, "R1 all flags");
    look(2'd3, 16'h0000, "R5 select 3");
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule